// File: doc/BRIEF.md
# Mask-Contracted Multiply-Accumulate Element

This processing element multiplies an unsigned activation by an unsigned weight and adds the product into a wide accumulator. The weight carries a set of bit positions that are fixed at zero when the design is built. A parameter gives these positions. The multiplier builds no partial-product row for a fixed-zero position, and it has no reduction logic for such a row. The remaining rows pass through a chain of carry-save 3:2 compressors and then one final carry-propagate adder. This shortens the multiplier's critical path, and the product stays exactly equal to the full product of the same operands.

The element is a two-stage pipeline. The multiplier stage registers the product. The accumulator stage adds that product exactly, at full width. The element accepts one term per cycle. A clear marks the first term of a new output: the accumulator takes the bias plus that product, and the old sum is dropped. A term counter raises a one-cycle done pulse when the window holds `CHANNELS*KERNEL*KERNEL` terms. The sum is then frozen until the next clear. The accumulator width is `ACT_W + WGT_W + clog2(terms)`, so a full window of worst-case products cannot wrap.

Top module: `masked_mac_pe`

## Requirements
- R1: For any activation and any legal weight (all mask bits zero), the term added equals the exact unsigned product act*wgt. With the default mask 8'h24 (positions 2 and 5 fixed at zero), the largest legal weight is 8'hDB.
- R2: Each unmasked weight bit position i contributes exactly act<<i. A weight that has a masked bit set is a usage error and is flagged in simulation.
- R3: A term presented on a clock edge appears in `acc_out` after the second rising edge that follows. One term is accepted on every cycle.
- R4: A valid term with `in_clear` high loads the accumulator with bias+product and starts a new window at a count of one. The previous sum is discarded.
- R5: A valid term with `in_clear` low adds its product exactly. A full window of maximum products plus a small bias does not wrap.
- R6: `done_out` is high for exactly one cycle. That cycle is the one in which the window's last term (term `CHANNELS*KERNEL*KERNEL`) becomes visible in `acc_out`.
- R7: Once a window is complete, valid terms without clear are ignored. The sum is held, and done stays low, until the next clear.
- R8: A cycle with `in_valid` low changes neither the sum nor the count, whatever is on the operand inputs.
- R9: After synchronous active-low reset, `acc_out` is zero and `done_out` is low. Terms without a preceding clear accumulate from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Term present on the operand inputs |
| in_clear | input | 1 | This term starts a new output window |
| act_in | input | ACT_W (8) | Unsigned activation |
| wgt_in | input | WGT_W (8) | Unsigned weight, masked positions zero |
| bias_in | input | ACC_W (22) | Start value added on a clear term |
| acc_out | output | ACC_W (22) | Accumulated sum |
| done_out | output | 1 | One-cycle pulse when the window completes |

## Verification
The hardest states to reach are the ones at the end of a window. Two are of interest. In the first, extra terms arrive after the count is full. In the second, a clear arrives on the cycle right after the last term, while the done pulse is still in flight. To reach them, the bench streams a full window of worst-case operands back to back. It then sends surplus terms, and then a clear with no gap. A cycle-accurate reference in the bench compares the sum and the done pulse on every cycle. Single-bit weights cover each remaining partial-product row on its own.

// File: rtl/mcm_pkg.sv
// Package: helper functions shared by the mask-contracted MAC.
// Assumes masks are no wider than 64 bits.
package mcm_pkg;

    // Number of weight bit positions that are not fixed at zero.
    function automatic int kept_count(input logic [63:0] mask, input int width);
        int n;
        n = 0;
        for (int i = 0; i < width; i++) begin
            if (!mask[i]) n++;
        end
        return n;
    endfunction

    // Bit position of the j-th unmasked weight bit (counting from LSB).
    function automatic int kept_index(input logic [63:0] mask, input int width, input int j);
        int n;
        int pos;
        n   = 0;
        pos = 0;
        for (int i = 0; i < width; i++) begin
            if (!mask[i]) begin
                if (n == j) pos = i;
                n++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/mcm_pp_rows.sv
// Module: builds one partial-product row for each unmasked weight bit.
// Assumes kept_w holds the weight bits at the unmasked positions, in LSB-first order.
module mcm_pp_rows #(
    parameter int ACT_W = 8,
    parameter int WGT_W = 8,
    parameter logic [WGT_W-1:0] MASK = '0,
    parameter int ROWS = 1,
    localparam int PW = ACT_W + WGT_W
) (
    input  logic [ACT_W-1:0]           act,
    input  logic [ROWS-1:0]            kept_w,
    output logic [ROWS-1:0][PW-1:0]    rows
);
    for (genvar j = 0; j < ROWS; j++) begin : g_row
        localparam int KB = mcm_pkg::kept_index(64'(MASK), WGT_W, j);
        // Row j: the activation gated by its weight bit and shifted to that bit's weight.
        assign rows[j] = PW'({ACT_W{kept_w[j]}} & act) << KB;
    end
endmodule

// File: rtl/mcm_csa_reduce.sv
// Module: reduces the partial-product rows with a chain of carry-save 3:2 compressors
// and one final carry-propagate adder. Assumes the true sum fits in PW bits.
module mcm_csa_reduce #(
    parameter int PW = 16,
    parameter int ROWS = 1
) (
    input  logic [ROWS-1:0][PW-1:0] rows,
    output logic [PW-1:0]           prod
);
    logic [ROWS-1:0][PW-1:0] s_vec;
    logic [ROWS-1:0][PW-1:0] c_vec;

    for (genvar j = 0; j < ROWS; j++) begin : g_csa
        if (j == 0) begin : g_first
            // The first row seeds the redundant pair.
            assign s_vec[0] = rows[0];
            assign c_vec[0] = '0;
        end else begin : g_next
            // 3:2 compression of the running sum, the running carry and the next row.
            assign s_vec[j] = s_vec[j-1] ^ c_vec[j-1] ^ rows[j];
            assign c_vec[j] = ((s_vec[j-1] & c_vec[j-1]) |
                               (s_vec[j-1] & rows[j])    |
                               (c_vec[j-1] & rows[j])) << 1;
        end
    end

    // Final carry-propagate adder that resolves the redundant form.
    assign prod = s_vec[ROWS-1] + c_vec[ROWS-1];
endmodule

// File: rtl/mcm_mult_stage.sv
// Module: pipeline stage 1. Forms the contracted product and registers it together
// with the valid, clear and bias of its term. Assumes at least one unmasked weight bit.
module mcm_mult_stage #(
    parameter int ACT_W = 8,
    parameter int WGT_W = 8,
    parameter logic [WGT_W-1:0] MASK = '0,
    parameter int ACC_W = 22,
    localparam int PW = ACT_W + WGT_W,
    localparam int ROWS = mcm_pkg::kept_count(64'(MASK), WGT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_clear,
    input  logic [ACT_W-1:0] act,
    input  logic [WGT_W-1:0] wgt,
    input  logic [ACC_W-1:0] bias,
    output logic             st_valid,
    output logic             st_clear,
    output logic [PW-1:0]    st_prod,
    output logic [ACC_W-1:0] st_bias
);
    logic [ROWS-1:0]         kept_w;
    logic [ROWS-1:0][PW-1:0] rows;
    logic [PW-1:0]           prod;

    for (genvar j = 0; j < ROWS; j++) begin : g_pick
        // Collect only the weight bits that may be one.
        assign kept_w[j] = wgt[mcm_pkg::kept_index(64'(MASK), WGT_W, j)];
    end

    mcm_pp_rows #(.ACT_W(ACT_W), .WGT_W(WGT_W), .MASK(MASK), .ROWS(ROWS)) u_rows (
        .act    (act),
        .kept_w (kept_w),
        .rows   (rows)
    );

    mcm_csa_reduce #(.PW(PW), .ROWS(ROWS)) u_reduce (
        .rows (rows),
        .prod (prod)
    );

    // Stage register between the multiplier and the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_clear <= 1'b0;
            st_prod  <= '0;
            st_bias  <= '0;
        end else begin
            st_valid <= in_valid;
            st_clear <= in_clear;
            st_prod  <= prod;
            st_bias  <= bias;
        end
    end

    // A weight reaching the multiplier must have every masked position at zero.
    p_wgt_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ((wgt & MASK) == '0));

    // The registered product matches a plain full-width multiply of the same operands.
    p_prod_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (st_prod == (PW'($past(act)) * PW'($past(wgt)))));
endmodule

// File: rtl/mcm_accum.sv
// Module: pipeline stage 2. Exact accumulator with a term counter and a done pulse.
// Assumes bias plus a full window of products fits in ACC_W bits.
module mcm_accum #(
    parameter int PW = 16,
    parameter int ACC_W = 22,
    parameter int TERMS = 36,
    localparam int CNT_W = $clog2(TERMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             st_clear,
    input  logic [PW-1:0]    st_prod,
    input  logic [ACC_W-1:0] st_bias,
    output logic [ACC_W-1:0] acc,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERMS);
    localparam logic [CNT_W-1:0] PRE  = CNT_W'(TERMS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] prod_ext;

    assign prod_ext = ACC_W'(st_prod);

    // Accumulates, counts terms, and pulses done on the window's last term.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st_valid) begin
                if (st_clear) begin
                    acc   <= st_bias + prod_ext;
                    cnt_q <= CNT_W'(1);
                    done  <= (TERMS == 1);
                end else if (cnt_q != LAST) begin
                    acc   <= acc + prod_ext;
                    cnt_q <= cnt_q + 1'b1;
                    done  <= (cnt_q == PRE);
                end
            end
        end
    end

    // The count never passes the window length.
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // Done comes only with a full window.
    p_done_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == LAST));

    // A clear term restarts the window at a count of one.
    p_clear_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_clear) |=> (cnt_q == CNT_W'(1)));

    // A full window holds its sum until a clear arrives.
    p_hold_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == LAST) && !(st_valid && st_clear)) |=> $stable(acc));

    // An empty pipeline slot leaves the sum and the count alone.
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> ($stable(acc) && $stable(cnt_q)));

    if (TERMS > 1) begin : g_pulse_chk
        // Done lasts one cycle.
        p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !done);
    end
endmodule

// File: rtl/masked_mac_pe.sv
// Module: top of the mask-contracted MAC element. Two-stage pipeline: a contracted
// multiplier feeding an exact accumulator. Assumes MASK leaves at least one weight bit free.
module masked_mac_pe #(
    parameter int ACT_W = 8,
    parameter int WGT_W = 8,
    parameter logic [WGT_W-1:0] MASK = 8'h24,
    parameter int CHANNELS = 4,
    parameter int KERNEL = 3,
    localparam int TERMS = CHANNELS * KERNEL * KERNEL,
    localparam int PW = ACT_W + WGT_W,
    localparam int ACC_W = PW + $clog2(TERMS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_clear,
    input  logic [ACT_W-1:0] act_in,
    input  logic [WGT_W-1:0] wgt_in,
    input  logic [ACC_W-1:0] bias_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             done_out
);
    logic             st_valid;
    logic             st_clear;
    logic [PW-1:0]    st_prod;
    logic [ACC_W-1:0] st_bias;

    mcm_mult_stage #(.ACT_W(ACT_W), .WGT_W(WGT_W), .MASK(MASK), .ACC_W(ACC_W)) u_mult (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_clear (in_clear),
        .act      (act_in),
        .wgt      (wgt_in),
        .bias     (bias_in),
        .st_valid (st_valid),
        .st_clear (st_clear),
        .st_prod  (st_prod),
        .st_bias  (st_bias)
    );

    mcm_accum #(.PW(PW), .ACC_W(ACC_W), .TERMS(TERMS)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_valid),
        .st_clear (st_clear),
        .st_prod  (st_prod),
        .st_bias  (st_bias),
        .acc      (acc_out),
        .done     (done_out)
    );

    // A term entering the pipe shows in the sum two edges later (checked from the ports).
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !$past(in_valid)) |=> $stable(acc_out));
endmodule

// File: tb/masked_mac_pe_bench.sv
`timescale 1ns/1ps
module masked_mac_pe_bench;
    localparam int ACT_W = 8;
    localparam int WGT_W = 8;
    localparam logic [7:0] MASK = 8'h24;
    localparam int TERMS = 36;
    localparam int ACC_W = 22;
    localparam longint ACC_MOD = longint'(1) << ACC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_clear = 1'b0;
    logic [7:0] act_in = '0;
    logic [7:0] wgt_in = '0;
    logic [ACC_W-1:0] bias_in = '0;
    logic [ACC_W-1:0] acc_out;
    logic done_out;

    int checks = 0;
    int fails = 0;

    // reference state: model after the newest term, and the two previous snapshots
    longint m_acc = 0;
    int m_cnt = 0;
    bit m_done = 0;
    longint h1_acc = 0, h2_acc = 0;
    bit h1_done = 0, h2_done = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    masked_mac_pe #(.MASK(MASK), .CHANNELS(4), .KERNEL(3)) u_masked_mac_pe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
        .act_in(act_in), .wgt_in(wgt_in), .bias_in(bias_in),
        .acc_out(acc_out), .done_out(done_out)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: check outputs against the model two terms back, then drive a term.
    task automatic send(input bit v, input bit c, input logic [7:0] a,
                        input logic [7:0] w, input longint b, input string tag);
        longint p;
        @(negedge clk);
        chk({tag, " sum"}, longint'(acc_out), h2_acc % ACC_MOD);
        chk({tag, " done"}, longint'(done_out), longint'(h2_done));
        in_valid = v; in_clear = c; act_in = a; wgt_in = w; bias_in = ACC_W'(b);
        p = longint'(a) * longint'(w);
        m_done = 0;
        if (v) begin
            if (c) begin
                m_acc = b + p; m_cnt = 1; m_done = (TERMS == 1);
            end else if (m_cnt != TERMS) begin
                m_acc += p; m_cnt++; m_done = (m_cnt == TERMS);
            end
        end
        h2_acc = h1_acc; h2_done = h1_done;
        h1_acc = m_acc;  h1_done = m_done;
    endtask

    task automatic flush(input string tag);
        send(0, 0, 8'hA5, 8'h5A, 0, tag);
        send(0, 0, 8'h3C, 8'hC3, 0, tag);
    endtask

    function automatic logic [7:0] rnd_byte();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R9 reset sum", longint'(acc_out), 0);
        chk("R9 reset done", longint'(done_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: terms without a clear accumulate from zero
        send(1, 0, 8'd7, 8'd9, 0, "R9");
        flush("R9");
    endtask

    task automatic t_products();
        // R1: single-term windows across operand patterns, R4 with zero bias
        send(1, 1, 8'hFF, 8'hDB, 0, "R1 max");
        send(1, 1, 8'h00, 8'hDB, 0, "R1 zero act");
        send(1, 1, 8'hFF, 8'h00, 0, "R1 zero wgt");
        send(1, 1, 8'h81, 8'h99, 0, "R1 mix");
        send(1, 1, 8'h55, 8'h4A, 0, "R1 alt");
        // R2: each unmasked position alone
        for (int i = 0; i < 8; i++) begin
            if (!MASK[i]) send(1, 1, 8'hB7, 8'(1 << i), 0, "R2 row");
        end
        flush("R1");
    endtask

    task automatic t_bias();
        send(1, 1, 8'd3, 8'h11, 1000, "R4 bias");
        send(1, 0, 8'd2, 8'h02, 0, "R4 add");
        send(1, 1, 8'd1, 8'h01, 77, "R4 discard");
        flush("R4");
    endtask

    task automatic t_full_window();
        // R5/R6/R3: back-to-back worst case, then surplus terms (R7) and an immediate clear
        send(1, 1, 8'hFF, 8'hDB, 5, "R5 first");
        for (int k = 1; k < TERMS; k++) send(1, 0, 8'hFF, 8'hDB, 0, "R3 R5 R6 stream");
        for (int k = 0; k < 3; k++) send(1, 0, 8'hFF, 8'hDB, 0, "R7 surplus");
        send(0, 0, 8'hFF, 8'hDB, 0, "R7 idle");
        send(0, 0, 8'h12, 8'h34 & ~MASK, 0, "R7 idle");
        send(0, 0, 8'h00, 8'h00, 0, "R7 held");
        send(1, 1, 8'd4, 8'd8, 0, "R4 restart");
        flush("R4");
    endtask

    task automatic t_restart_on_done();
        // R6/R4: clear arrives the cycle right after the last term
        send(1, 1, 8'd1, 8'd1, 0, "R6 win");
        for (int k = 1; k < TERMS; k++) send(1, 0, 8'd2, 8'd3, 0, "R6 win");
        send(1, 1, 8'd9, 8'd10, 0, "R4 back2back");
        send(1, 0, 8'd1, 8'd1, 0, "R4 back2back");
        flush("R6");
    endtask

    task automatic t_bubbles();
        // R8: invalid cycles with changing operands in a random window
        send(1, 1, rnd_byte(), rnd_byte() & ~MASK, 123, "R8 start");
        for (int k = 1; k < TERMS; k++) begin
            send(0, 0, rnd_byte(), rnd_byte() & ~MASK, 999, "R8 bubble");
            send(1, 0, rnd_byte(), rnd_byte() & ~MASK, 0, "R8 R5 term");
        end
        flush("R8");
    endtask

    initial begin
        t_reset();
        t_products();
        t_bias();
        t_full_window();
        t_restart_on_done();
        t_bubbles();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule